// File: doc/BRIEF.md
# Outbound Region Address Translator

This block maps addresses that fall inside a fixed 64 MiB AXI slave window onto 64-bit PCIe bus addresses. The window is split into one 32 MiB region at its base, region 0. Above it sit 32 regions of 1 MiB each, numbered 1 to 32. Each region holds a translated upper address, a count of low address bits that pass through unchanged, and a transaction type code. A lookup port takes an AXI address and returns, with no clock delay, the translated address, the type code and a miss flag.

Software fills the region table through a word-wide programming port. The byte offset of a write selects the region (offset bits 10:5) and the word within it (offset bits 4:2). Word 0 (offset 0x0) holds the pass field in bits 5:0 and translated address bits 31:8 in bits 31:8. Word 1 (offset 0x4) holds translated address bits 63:32. Word 2 (offset 0x8) is the descriptor: bit 23 must be set and bits 3:0 hold the type. Type 2 is a memory write and type 6 is an I/O write. Word 3 (offset 0xC) and offsets 0x10 to 0x1C exist but store nothing.

A two-state controller checks every write before it commits. In P_IDLE, an asserted write is captured and the controller takes the transition T_CAPTURE to P_CHECK. In P_CHECK the write is judged, the table entry is updated or left alone, the error flag is set or cleared, and the controller takes the transition T_RESOLVE back to P_IDLE.

Top module: `obt_translator`

## Requirements
- R1: After reset, prog_busy and prog_err are 0 and every lookup misses.
- R2: A lookup address whose bits 31:26 differ from the window base misses. Within the window, offsets below 32 MiB select region 0. The offset 32 MiB + (n-1) MiB selects region n, for n = 1 to 32.
- R3: On a hit, bits field..0 of lk_out_addr come from lk_addr. All higher bits come from {word 1, word 0 bits 31:8, 8'h00} of the selected region.
- R4: A word 0 write is rejected when its field is below 7. It is also rejected when the field is above 24 for region 0, or above 19 for any other region, because 2 << field would exceed the region size. The 6-bit field cannot exceed 63. A rejected write leaves the table unchanged and sets prog_err.
- R5: A write whose region index (offset bits 10:5) is 33 or more is rejected and sets prog_err.
- R6: A descriptor write is accepted only when bit 23 is set and bits 3:0 equal 2 or 6. Otherwise it is rejected. lk_type returns the last accepted type, or 0 if no descriptor write has been accepted.
- R7: A lookup in a region whose word 0 has never been accepted misses. On a miss, lk_out_addr and lk_type are 0.
- R8: A write presented while prog_busy is 0 raises prog_busy for exactly one cycle. Its effect is visible after the following clock edge. A write presented while prog_busy is 1 is dropped.
- R9: An in-range write to word 3 or to offsets 0x10 to 0x1C changes no lookup result and clears prog_err.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| prog_we | input | 1 | Programming write strobe |
| prog_addr | input | 11 | Programming byte offset: region in bits 10:5, word in bits 4:2 |
| prog_wdata | input | 32 | Programming write data |
| prog_busy | output | 1 | High while a captured write is being checked |
| prog_err | output | 1 | Result of the last judged write: 1 if it was rejected |
| lk_addr | input | 32 | AXI address to translate |
| lk_out_addr | output | 64 | Translated PCIe address, 0 on a miss |
| lk_type | output | 4 | Transaction type of the hit region, 0 on a miss |
| lk_miss | output | 1 | Address is outside the window or in an unprogrammed region |

## Verification
The bound checker watches, on every cycle, the properties that hold for any stimulus:
- the busy pulse lasts one cycle and follows every accepted strobe;
- prog_err moves only after a check cycle;
- out-of-window addresses always miss;
- a miss drives zero address and zero type;
- a hit passes the low byte through;
- a hit only reports legal type codes.

Only the bench scenarios can show the rest:
- the exact translated values and which region an address lands in;
- that each kind of rejected write leaves the table unchanged;
- the pass-field limits for region 0 versus the other regions;
- that a write arriving during the busy cycle is lost.

// File: rtl/obt_pkg.sv
package obt_pkg;

    typedef enum logic [0:0] {
        P_IDLE  = 1'b0,
        P_CHECK = 1'b1
    } prog_state_e;

    localparam logic [2:0] WORD_LOW  = 3'd0;
    localparam logic [2:0] WORD_HIGH = 3'd1;
    localparam logic [2:0] WORD_DESC = 3'd2;

    localparam logic [3:0] KIND_MEM_WR = 4'd2;
    localparam logic [3:0] KIND_IO_WR  = 4'd6;

    localparam int PASS_MIN = 7;
    localparam int DESC_FLAG_BIT = 23;

    typedef struct packed {
        logic        valid;
        logic [5:0]  field;
        logic [23:0] lo;
        logic [31:0] hi;
        logic [3:0]  kind;
    } region_t;

endpackage

// File: rtl/obt_prog_fsm.sv
module obt_prog_fsm
    import obt_pkg::*;
#(
    parameter int NUM_REGIONS = 33,
    parameter int SUB_SHIFT   = 20,
    parameter int R0_SHIFT    = 25,
    parameter int IDX_W       = 6,
    parameter int PROG_AW     = 11
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               prog_we,
    input  logic [PROG_AW-1:0] prog_addr,
    input  logic [31:0]        prog_wdata,
    output logic               busy,
    output logic               err,
    output logic               cm_we,
    output logic [IDX_W-1:0]   cm_idx,
    output logic [2:0]         cm_word,
    output logic [31:0]        cm_data
);

    prog_state_e state_q, state_d;

    logic [PROG_AW-1:0] cap_addr_q;
    logic [31:0]        cap_data_q;
    logic               err_q;

    logic [IDX_W-1:0]   cap_idx;
    logic [2:0]         cap_word;
    logic               idx_ok;
    logic               word_ok;
    logic               accept;
    logic [5:0]         fld;
    int                 fld_lim;

    assign cap_idx  = cap_addr_q[PROG_AW-1:5];
    assign cap_word = cap_addr_q[4:2];
    assign fld      = cap_data_q[5:0];
    assign idx_ok   = int'(cap_idx) < NUM_REGIONS;
    assign fld_lim  = (cap_idx == '0) ? (R0_SHIFT - 1) : (SUB_SHIFT - 1);

    // Per-word legality of the captured write
    always_comb begin
        unique case (cap_word)
            WORD_LOW:  word_ok = (int'(fld) >= PASS_MIN) && (int'(fld) <= fld_lim);
            WORD_DESC: word_ok = cap_data_q[DESC_FLAG_BIT] &&
                                 ((cap_data_q[3:0] == KIND_MEM_WR) ||
                                  (cap_data_q[3:0] == KIND_IO_WR));
            default:   word_ok = 1'b1;
        endcase
    end

    assign accept = idx_ok && word_ok;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= P_IDLE;
        else        state_q <= state_d;
    end

    // Next state: T_CAPTURE and T_RESOLVE
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            P_IDLE:  if (prog_we) state_d = P_CHECK;
            P_CHECK: state_d = P_IDLE;
            default: state_d = P_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        busy    = 1'b0;
        cm_we   = 1'b0;
        cm_idx  = cap_idx;
        cm_word = cap_word;
        cm_data = cap_data_q;
        unique case (state_q)
            P_IDLE:  busy = 1'b0;
            P_CHECK: begin
                busy  = 1'b1;
                cm_we = accept && (cap_word <= WORD_DESC);
            end
            default: busy = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_addr_q <= '0;
            cap_data_q <= '0;
        end else if (state_q == P_IDLE && prog_we) begin
            cap_addr_q <= prog_addr;
            cap_data_q <= prog_wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)                 err_q <= 1'b0;
        else if (state_q == P_CHECK) err_q <= !accept;
    end

    assign err = err_q;

endmodule

// File: rtl/obt_region_table.sv
module obt_region_table
    import obt_pkg::*;
#(
    parameter int NUM_REGIONS = 33,
    parameter int IDX_W       = 6
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         cm_we,
    input  logic [IDX_W-1:0]             cm_idx,
    input  logic [2:0]                   cm_word,
    input  logic [31:0]                  cm_data,
    output region_t [NUM_REGIONS-1:0]    tbl
);

    for (genvar g = 0; g < NUM_REGIONS; g++) begin : g_region
        region_t ent_q;
        logic    sel;

        assign sel = cm_we && (cm_idx == IDX_W'(g));

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                ent_q <= '0;
            end else if (sel) begin
                unique case (cm_word)
                    WORD_LOW: begin
                        ent_q.valid <= 1'b1;
                        ent_q.field <= cm_data[5:0];
                        ent_q.lo    <= cm_data[31:8];
                    end
                    WORD_HIGH: ent_q.hi   <= cm_data;
                    WORD_DESC: ent_q.kind <= cm_data[3:0];
                    default:   ent_q      <= ent_q;
                endcase
            end
        end

        assign tbl[g] = ent_q;
    end

endmodule

// File: rtl/obt_window_decode.sv
module obt_window_decode #(
    parameter int          AW        = 32,
    parameter logic [31:0] WIN_BASE  = 32'h4000_0000,
    parameter int          SUB_SHIFT = 20,
    parameter int          R0_SHIFT  = 25,
    parameter int          IDX_W     = 6
) (
    input  logic [AW-1:0]    addr,
    output logic             in_win,
    output logic [IDX_W-1:0] idx
);

    localparam int WIN_SHIFT = R0_SHIFT + 1;

    logic [WIN_SHIFT-1:0] off;

    assign in_win = (addr[AW-1:WIN_SHIFT] == WIN_BASE[AW-1:WIN_SHIFT]);
    assign off    = addr[WIN_SHIFT-1:0];

    always_comb begin
        if (off[R0_SHIFT]) idx = IDX_W'(off[R0_SHIFT-1:SUB_SHIFT]) + IDX_W'(1);
        else               idx = '0;
    end

endmodule

// File: rtl/obt_lookup.sv
module obt_lookup
    import obt_pkg::*;
#(
    parameter int NUM_REGIONS = 33,
    parameter int IDX_W       = 6,
    parameter int AW          = 32
) (
    input  region_t [NUM_REGIONS-1:0] tbl,
    input  logic                      in_win,
    input  logic [IDX_W-1:0]          idx,
    input  logic [AW-1:0]             addr,
    output logic [63:0]               out_addr,
    output logic [3:0]                out_kind,
    output logic                      miss
);

    region_t     ent;
    logic [63:0] keep;
    logic [63:0] base;
    logic [63:0] wide_in;
    logic        hit;

    assign ent     = (int'(idx) < NUM_REGIONS) ? tbl[idx] : '0;
    assign hit     = in_win && ent.valid;
    assign keep    = ~(64'hFFFF_FFFF_FFFF_FFFF << ({1'b0, ent.field} + 7'd1));
    assign base    = {ent.hi, ent.lo, 8'h00};
    assign wide_in = {{(64-AW){1'b0}}, addr};

    assign out_addr = hit ? ((base & ~keep) | (wide_in & keep)) : 64'd0;
    assign out_kind = hit ? ent.kind : 4'd0;
    assign miss     = !hit;

endmodule

// File: rtl/obt_translator.sv
module obt_translator
    import obt_pkg::*;
#(
    parameter int          NUM_REGIONS = 33,
    parameter int          SUB_SHIFT   = 20,
    parameter int          R0_SHIFT    = 25,
    parameter int          AW          = 32,
    parameter logic [31:0] WIN_BASE    = 32'h4000_0000,
    localparam int         IDX_W       = $clog2(NUM_REGIONS),
    localparam int         PROG_AW     = IDX_W + 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               prog_we,
    input  logic [PROG_AW-1:0] prog_addr,
    input  logic [31:0]        prog_wdata,
    output logic               prog_busy,
    output logic               prog_err,
    input  logic [AW-1:0]      lk_addr,
    output logic [63:0]        lk_out_addr,
    output logic [3:0]         lk_type,
    output logic               lk_miss
);

    logic                      cm_we;
    logic [IDX_W-1:0]          cm_idx;
    logic [2:0]                cm_word;
    logic [31:0]               cm_data;
    region_t [NUM_REGIONS-1:0] tbl;
    logic                      in_win;
    logic [IDX_W-1:0]          lk_idx;

    obt_prog_fsm #(
        .NUM_REGIONS(NUM_REGIONS), .SUB_SHIFT(SUB_SHIFT), .R0_SHIFT(R0_SHIFT),
        .IDX_W(IDX_W), .PROG_AW(PROG_AW)
    ) u_fsm (
        .clk(clk), .rst_n(rst_n), .prog_we(prog_we), .prog_addr(prog_addr),
        .prog_wdata(prog_wdata), .busy(prog_busy), .err(prog_err),
        .cm_we(cm_we), .cm_idx(cm_idx), .cm_word(cm_word), .cm_data(cm_data)
    );

    obt_region_table #(.NUM_REGIONS(NUM_REGIONS), .IDX_W(IDX_W)) u_tbl (
        .clk(clk), .rst_n(rst_n), .cm_we(cm_we), .cm_idx(cm_idx),
        .cm_word(cm_word), .cm_data(cm_data), .tbl(tbl)
    );

    obt_window_decode #(
        .AW(AW), .WIN_BASE(WIN_BASE), .SUB_SHIFT(SUB_SHIFT),
        .R0_SHIFT(R0_SHIFT), .IDX_W(IDX_W)
    ) u_dec (
        .addr(lk_addr), .in_win(in_win), .idx(lk_idx)
    );

    obt_lookup #(.NUM_REGIONS(NUM_REGIONS), .IDX_W(IDX_W), .AW(AW)) u_lk (
        .tbl(tbl), .in_win(in_win), .idx(lk_idx), .addr(lk_addr),
        .out_addr(lk_out_addr), .out_kind(lk_type), .miss(lk_miss)
    );

endmodule

// File: rtl/obt_translator_chk.sv
module obt_translator_chk #(
    parameter int          AW       = 32,
    parameter int          R0_SHIFT = 25,
    parameter logic [31:0] WIN_BASE = 32'h4000_0000
) (
    input logic          clk,
    input logic          rst_n,
    input logic          prog_we,
    input logic          prog_busy,
    input logic          prog_err,
    input logic [AW-1:0] lk_addr,
    input logic [63:0]   lk_out_addr,
    input logic [3:0]    lk_type,
    input logic          lk_miss
);

    localparam int WIN_SHIFT = R0_SHIFT + 1;

    p_busy_one_cycle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        prog_busy |=> !prog_busy);

    p_idle_accept_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!prog_busy && prog_we) |=> prog_busy);

    p_err_only_after_check_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !prog_busy |=> $stable(prog_err));

    p_outside_window_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_addr[AW-1:WIN_SHIFT] != WIN_BASE[AW-1:WIN_SHIFT]) |-> lk_miss);

    p_miss_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        lk_miss |-> (lk_out_addr == 64'd0 && lk_type == 4'd0));

    p_low_byte_pass_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_miss |-> (lk_out_addr[7:0] == lk_addr[7:0]));

    p_type_legal_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_miss |-> (lk_type == 4'd0 || lk_type == 4'd2 || lk_type == 4'd6));

endmodule

bind obt_translator obt_translator_chk #(
    .AW(AW), .R0_SHIFT(R0_SHIFT), .WIN_BASE(WIN_BASE)
) u_chk (
    .clk(clk), .rst_n(rst_n), .prog_we(prog_we), .prog_busy(prog_busy),
    .prog_err(prog_err), .lk_addr(lk_addr), .lk_out_addr(lk_out_addr),
    .lk_type(lk_type), .lk_miss(lk_miss)
);

// File: tb/obt_translator_tb.sv
module obt_translator_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        prog_we = 1'b0;
    logic [10:0] prog_addr = '0;
    logic [31:0] prog_wdata = '0;
    logic        prog_busy, prog_err;
    logic [31:0] lk_addr = '0;
    logic [63:0] lk_out_addr;
    logic [3:0]  lk_type;
    logic        lk_miss;

    int n_tests = 0;
    int n_fail  = 0;

    always #2.5 clk = ~clk;

    obt_translator u_dut (
        .clk(clk), .rst_n(rst_n), .prog_we(prog_we), .prog_addr(prog_addr),
        .prog_wdata(prog_wdata), .prog_busy(prog_busy), .prog_err(prog_err),
        .lk_addr(lk_addr), .lk_out_addr(lk_out_addr), .lk_type(lk_type),
        .lk_miss(lk_miss)
    );

    typedef struct packed {
        logic [31:0] a;
        logic [63:0] x;
        logic [3:0]  t;
        logic        m;
    } vec_t;

    // R2 / R3 / R7 lookup vectors after the base programming
    localparam vec_t VECS [8] = '{
        '{32'h4000_1234, 64'h0000_00AB_1234_1234, 4'd2, 1'b0},
        '{32'h41FF_FFFF, 64'h0000_00AB_1234_FFFF, 4'd2, 1'b0},
        '{32'h4200_0ABC, 64'h0000_0001_00AB_CABC, 4'd6, 1'b0},
        '{32'h43F0_0001, 64'h0000_0002_FFF0_0001, 4'd2, 1'b0},
        '{32'h4250_0000, 64'h0,                   4'd0, 1'b1},
        '{32'h3FFF_FFFF, 64'h0,                   4'd0, 1'b1},
        '{32'h4400_0000, 64'h0,                   4'd0, 1'b1},
        '{32'h4210_0000, 64'h0,                   4'd0, 1'b1}
    };

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [10:0] a, input logic [31:0] d);
        @(negedge clk);
        prog_we = 1'b1; prog_addr = a; prog_wdata = d;
        @(negedge clk);
        prog_we = 1'b0;
        @(negedge clk);
    endtask

    task automatic look(input string req, input logic [31:0] a,
                        input logic [63:0] x, input logic [3:0] t, input logic m);
        lk_addr = a;
        #1;
        check(req, lk_out_addr, x);
        check(req, {60'd0, lk_type}, {60'd0, t});
        check(req, {63'd0, lk_miss}, {63'd0, m});
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 busy", {63'd0, prog_busy}, 64'd0);
        check("R1 err",  {63'd0, prog_err},  64'd0);
        look("R1 lookup", 32'h4000_1234, 64'd0, 4'd0, 1'b1);

        // base programming: regions 0, 1, 32
        wr(11'h000, 32'h1234_560F); wr(11'h004, 32'h0000_00AB); wr(11'h008, 32'h0080_0002);
        wr(11'h020, 32'h00AB_C00B); wr(11'h024, 32'h0000_0001); wr(11'h028, 32'h0080_0006);
        wr(11'h400, 32'hFFF0_0013); wr(11'h404, 32'h0000_0002); wr(11'h408, 32'h0080_0002);
        check("R4 legal writes err", {63'd0, prog_err}, 64'd0);

        for (int i = 0; i < 8; i++)
            look("R3 vector", VECS[i].a, VECS[i].x, VECS[i].t, VECS[i].m);

        // R8 busy pulse and dropped write; region 6 minimum field 7
        @(negedge clk);
        prog_we = 1'b1; prog_addr = 11'h0C0; prog_wdata = 32'h7777_7707;
        @(negedge clk);
        check("R8 busy high", {63'd0, prog_busy}, 64'd1);
        prog_addr = 11'h0C4; prog_wdata = 32'h0000_0055;
        @(negedge clk);
        prog_we = 1'b0;
        check("R8 busy low", {63'd0, prog_busy}, 64'd0);
        @(negedge clk);
        look("R8 dropped write", 32'h4250_0012, 64'h0000_0000_7777_7712, 4'd0, 1'b0);

        // R4 rejects
        wr(11'h000, 32'hDEAD_BE06);
        check("R4 field low err", {63'd0, prog_err}, 64'd1);
        look("R4 unchanged r0", 32'h4000_1234, 64'h0000_00AB_1234_1234, 4'd2, 1'b0);
        wr(11'h020, 32'h0000_0014);
        check("R4 size r1 err", {63'd0, prog_err}, 64'd1);
        look("R4 unchanged r1", 32'h4200_0ABC, 64'h0000_0001_00AB_CABC, 4'd6, 1'b0);
        wr(11'h000, 32'h0000_0019);
        check("R4 size r0 err", {63'd0, prog_err}, 64'd1);

        // R9 empty offsets
        wr(11'h010, 32'hFFFF_FFFF);
        check("R9 err cleared", {63'd0, prog_err}, 64'd0);
        look("R9 unchanged", 32'h4000_1234, 64'h0000_00AB_1234_1234, 4'd2, 1'b0);
        wr(11'h00C, 32'hFFFF_FFFF);
        check("R9 desc1 err", {63'd0, prog_err}, 64'd0);
        look("R9 desc1 unchanged", 32'h41FF_FFFF, 64'h0000_00AB_1234_FFFF, 4'd2, 1'b0);

        // R5 region out of range
        wr(11'h420, 32'h0000_000F);
        check("R5 err", {63'd0, prog_err}, 64'd1);
        look("R5 r32 unchanged", 32'h43F0_0001, 64'h0000_0002_FFF0_0001, 4'd2, 1'b0);

        // R6 descriptor checks
        wr(11'h028, 32'h0000_0006);
        check("R6 no flag err", {63'd0, prog_err}, 64'd1);
        look("R6 type kept", 32'h4200_0ABC, 64'h0000_0001_00AB_CABC, 4'd6, 1'b0);
        wr(11'h028, 32'h0080_0003);
        check("R6 bad type err", {63'd0, prog_err}, 64'd1);
        wr(11'h028, 32'h0080_0002);
        check("R6 good err", {63'd0, prog_err}, 64'd0);
        look("R6 new type", 32'h4200_0ABC, 64'h0000_0001_00AB_CABC, 4'd2, 1'b0);

        // R4 upper limits accepted
        wr(11'h000, 32'h1234_5618);
        check("R4 r0 field 24", {63'd0, prog_err}, 64'd0);
        look("R4 r0 wide pass", 32'h41FF_FFFF, 64'h0000_00AB_13FF_FFFF, 4'd2, 1'b0);
        wr(11'h020, 32'h00AB_C013);
        check("R4 r1 field 19", {63'd0, prog_err}, 64'd0);
        look("R4 r1 wide pass", 32'h4200_0ABC, 64'h0000_0001_00A0_0ABC, 4'd2, 1'b0);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule